// File: doc/BRIEF.md
# Hex Text Serial-to-Bus Bridge

This block sits between a byte-wide serial receiver and transmitter on one side and a single-word memory bus master port on the other. A host sends printable text over the serial link. Each frame is eight hexadecimal digits, a command letter, and a carriage return and line feed. The bridge decodes the frame, loads its address register or runs one bus read or write, and sends a short text reply back through the transmit byte port.

The same serial link also carries a console stream. Every incoming byte with its top bit set belongs to the console. Such a byte is passed out on a separate console port with the top bit removed, and it has no effect on the frame decoder. Bytes with the top bit clear are bridge characters. While a bus transaction or a reply is still in progress, the bridge refuses all input bytes. This gives back-pressure without any buffering.

Top module: `hexbr_bridge`

## Requirements
- R1: An accepted input byte with bit 7 set appears on the console port in the same cycle as its bits 6:0, and is accepted only when the console port is ready. It leaves any partial frame untouched. A byte with bit 7 clear never reaches the console port.
- R2: A frame is exactly 8 hex digits, most significant nibble first, followed by a command letter, CR (0x0D) and LF (0x0A). Digits 0-9, a-f and A-F are all accepted. The command takes effect in the cycle that the LF is accepted.
- R3: Command letter 'A' (0x41) loads the frame's word into the address register. It starts no bus cycle and sends no reply.
- R4: Command letter 'W' (0x57) starts a bus write in the next cycle. cyc and stb are high, we is high, adr is the address register and the data out is the frame's word. All of these stay unchanged until a cycle with ack.
- R5: Command letter 'R' (0x52) starts a bus read with we low. The reply is the acknowledged data as 8 uppercase hex digits (most significant first), then 'R', CR and LF.
- R6: A completed write is answered with 'K' (0x4B), CR and LF.
- R7: The address register increases by one after each completed read or write.
- R8: Any character that does not fit the frame at its position discards the partial frame, and is itself dropped. The decoder then waits for the first digit of a new frame.
- R9: From the cycle after a read or write command is accepted until its last reply byte is accepted, input ready is low for both streams. At all other times it is high for bridge bytes and equal to console ready for console bytes.
- R10: Reply bytes have bit 7 clear. A presented reply byte stays valid and unchanged until transmit ready accepts it.
- R11: After synchronous reset, no bus cycle is active, no reply or console byte is valid, the address register is zero and the decoder waits for a first digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Received byte; bit 7 selects the console stream |
| in_valid | input | 1 | Received byte is present |
| in_ready | output | 1 | Bridge takes the received byte this cycle |
| con_data | output | 7 | Console byte with the stream bit removed |
| con_valid | output | 1 | Console byte is present |
| con_ready | input | 1 | Console sink takes the byte |
| tx_data | output | 8 | Reply byte for the transmitter |
| tx_valid | output | 1 | Reply byte is present |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_adr | output | ADDR_W | Bus word address |
| bus_dat_o | output | WORD_W | Bus write data |
| bus_dat_i | input | WORD_W | Bus read data |
| bus_ack | input | 1 | Bus acknowledge |

## Verification
The assertions check the local handshake rules on every cycle. The bus request stays frozen until ack and drops right after it. Input ready stays low while a bus cycle is open. No bus cycle overlaps a reply. Reply bytes hold steady under back-pressure and keep bit 7 clear. What a frame means can only be shown by the bench scenarios: command dispatch, digit case handling, address auto-increment, the exact reply text, and the discarding of malformed frames. The bench runs these against a behavioural model that it compares every cycle.

// File: rtl/hexbr_pkg.sv
package hexbr_pkg;

    localparam logic [6:0] CH_CR    = 7'h0D;
    localparam logic [6:0] CH_LF    = 7'h0A;
    localparam logic [6:0] CH_LOAD  = 7'h41;
    localparam logic [6:0] CH_WRITE = 7'h57;
    localparam logic [6:0] CH_READ  = 7'h52;
    localparam logic [6:0] CH_OK    = 7'h4B;

    typedef enum logic [1:0] {
        DS_DIGIT,
        DS_CMD,
        DS_CR,
        DS_LF
    } dec_state_e;

    typedef enum logic [1:0] {
        OP_LOAD,
        OP_WRITE,
        OP_READ
    } op_e;

    typedef struct packed {
        logic valid;
        op_e  op;
    } cmd_t;

    function automatic logic is_hex(input logic [6:0] ch);
        return (ch >= 7'h30 && ch <= 7'h39) ||
               (ch >= 7'h41 && ch <= 7'h46) ||
               (ch >= 7'h61 && ch <= 7'h66);
    endfunction

    // letters have bit 6 set, digits do not; low nibble of a letter is 1..6
    function automatic logic [3:0] hex_val(input logic [6:0] ch);
        return ch[6] ? (ch[3:0] + 4'd9) : ch[3:0];
    endfunction

    function automatic logic [6:0] hex_char(input logic [3:0] n);
        return (n < 4'd10) ? {3'b011, n} : (7'h37 + {3'b000, n});
    endfunction

endpackage

// File: rtl/hexbr_split.sv
module hexbr_split (
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       hold,
    output logic [6:0] con_data,
    output logic       con_valid,
    input  logic       con_ready,
    output logic [6:0] chr_data,
    output logic       chr_valid
);
    logic to_console;

    assign to_console = in_data[7];
    assign in_ready   = !hold && (to_console ? con_ready : 1'b1);
    assign con_valid  = in_valid && !hold && to_console;
    assign con_data   = in_data[6:0];
    assign chr_valid  = in_valid && !hold && !to_console;
    assign chr_data   = in_data[6:0];
endmodule

// File: rtl/hexbr_decoder.sv
module hexbr_decoder
    import hexbr_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chr_valid,
    input  logic [6:0]        chr_data,
    output cmd_t              cmd,
    output logic [WORD_W-1:0] cmd_word
);
    localparam int NDIG = WORD_W / 4;
    localparam int CW   = $clog2(NDIG + 1);
    localparam logic [CW-1:0] LAST_DIG = CW'(NDIG - 1);

    dec_state_e        st_q;
    logic [CW-1:0]     cnt_q;
    logic [WORD_W-1:0] word_q;
    op_e               op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= DS_DIGIT;
            cnt_q  <= '0;
            word_q <= '0;
            op_q   <= OP_LOAD;
        end else if (chr_valid) begin
            unique case (st_q)
                DS_DIGIT: begin
                    if (is_hex(chr_data)) begin
                        word_q <= {word_q[WORD_W-5:0], hex_val(chr_data)};
                        if (cnt_q == LAST_DIG) begin
                            cnt_q <= '0;
                            st_q  <= DS_CMD;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= '0;
                    end
                end
                DS_CMD: begin
                    st_q <= DS_CR;
                    if (chr_data == CH_LOAD)       op_q <= OP_LOAD;
                    else if (chr_data == CH_WRITE) op_q <= OP_WRITE;
                    else if (chr_data == CH_READ)  op_q <= OP_READ;
                    else                           st_q <= DS_DIGIT;
                end
                DS_CR:   st_q <= (chr_data == CH_CR) ? DS_LF : DS_DIGIT;
                DS_LF:   st_q <= DS_DIGIT;
                default: st_q <= DS_DIGIT;
            endcase
        end
    end

    assign cmd.valid = chr_valid && (st_q == DS_LF) && (chr_data == CH_LF);
    assign cmd.op    = op_q;
    assign cmd_word  = word_q;
endmodule

// File: rtl/hexbr_engine.sv
module hexbr_engine
    import hexbr_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [WORD_W-1:0] bus_dat_o,
    input  logic [WORD_W-1:0] bus_dat_i,
    input  logic              bus_ack,
    output logic              rep_start,
    output logic              rep_read,
    output logic [WORD_W-1:0] rep_word,
    output logic              busy
);
    logic              pend_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            we_q   <= 1'b0;
            addr_q <= '0;
            wdat_q <= '0;
        end else if (pend_q) begin
            if (bus_ack) begin
                pend_q <= 1'b0;
                addr_q <= addr_q + ADDR_W'(1);
            end
        end else if (cmd.valid) begin
            unique case (cmd.op)
                OP_LOAD:  addr_q <= ADDR_W'(cmd_word);
                OP_WRITE: begin
                    pend_q <= 1'b1;
                    we_q   <= 1'b1;
                    wdat_q <= cmd_word;
                end
                OP_READ: begin
                    pend_q <= 1'b1;
                    we_q   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign bus_cyc   = pend_q;
    assign bus_stb   = pend_q;
    assign bus_we    = we_q;
    assign bus_adr   = addr_q;
    assign bus_dat_o = wdat_q;
    assign rep_start = pend_q && bus_ack;
    assign rep_read  = !we_q;
    assign rep_word  = bus_dat_i;
    assign busy      = pend_q;
endmodule

// File: rtl/hexbr_reply.sv
module hexbr_reply
    import hexbr_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_read,
    input  logic [WORD_W-1:0] word,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              active
);
    localparam int NDIG = WORD_W / 4;
    localparam int IW   = $clog2(NDIG + 3);
    localparam logic [IW-1:0] IDX_TAG  = IW'(NDIG);
    localparam logic [IW-1:0] IDX_CR   = IW'(NDIG + 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(NDIG + 2);

    logic              act_q;
    logic              rd_q;
    logic [IW-1:0]     idx_q;
    logic [WORD_W-1:0] sh_q;
    logic [6:0]        ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            rd_q  <= 1'b0;
            idx_q <= '0;
            sh_q  <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            rd_q  <= is_read;
            sh_q  <= word;
            idx_q <= is_read ? '0 : IDX_TAG;
        end else if (act_q && tx_ready) begin
            if (idx_q == IDX_LAST) act_q <= 1'b0;
            else                   idx_q <= idx_q + 1'b1;
            if (idx_q < IDX_TAG)   sh_q  <= sh_q << 4;
        end
    end

    always_comb begin
        if (idx_q < IDX_TAG)       ch = hex_char(sh_q[WORD_W-1 -: 4]);
        else if (idx_q == IDX_TAG) ch = rd_q ? CH_READ : CH_OK;
        else if (idx_q == IDX_CR)  ch = CH_CR;
        else                       ch = CH_LF;
    end

    assign tx_data  = {1'b0, ch};
    assign tx_valid = act_q;
    assign active   = act_q;
endmodule

// File: rtl/hexbr_bridge.sv
module hexbr_bridge
    import hexbr_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [6:0]        con_data,
    output logic              con_valid,
    input  logic              con_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [WORD_W-1:0] bus_dat_o,
    input  logic [WORD_W-1:0] bus_dat_i,
    input  logic              bus_ack
);
    logic              hold;
    logic              eng_busy;
    logic              rep_active;
    logic [6:0]        chr_data;
    logic              chr_valid;
    cmd_t              cmd;
    logic [WORD_W-1:0] cmd_word;
    logic              rep_start;
    logic              rep_read;
    logic [WORD_W-1:0] rep_word;

    assign hold = eng_busy || rep_active;

    hexbr_split u_split (
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .hold      (hold),
        .con_data  (con_data),
        .con_valid (con_valid),
        .con_ready (con_ready),
        .chr_data  (chr_data),
        .chr_valid (chr_valid)
    );

    hexbr_decoder #(.WORD_W(WORD_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .cmd       (cmd),
        .cmd_word  (cmd_word)
    );

    hexbr_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .cmd_word  (cmd_word),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_adr   (bus_adr),
        .bus_dat_o (bus_dat_o),
        .bus_dat_i (bus_dat_i),
        .bus_ack   (bus_ack),
        .rep_start (rep_start),
        .rep_read  (rep_read),
        .rep_word  (rep_word),
        .busy      (eng_busy)
    );

    hexbr_reply #(.WORD_W(WORD_W)) u_rep (
        .clk      (clk),
        .rst      (rst),
        .start    (rep_start),
        .is_read  (rep_read),
        .word     (rep_word),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .active   (rep_active)
    );
endmodule

// File: rtl/hexbr_bridge_checker.sv
module hexbr_bridge_checker #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              bus_cyc,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_adr,
    input logic [WORD_W-1:0] bus_dat_o,
    input logic              bus_ack
);
    a_r4_request_held: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_adr) && $stable(bus_we) && $stable(bus_dat_o)));

    a_r4_single_cycle_per_cmd: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_ack) |=> !bus_cyc);

    a_r9_stall_during_bus: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> !in_ready);

    a_r9_reply_after_bus: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (!bus_cyc && !in_ready));

    a_r10_reply_held: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r10_reply_msb_clear: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !tx_data[7]);
endmodule

bind hexbr_bridge hexbr_bridge_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .bus_cyc   (bus_cyc),
    .bus_we    (bus_we),
    .bus_adr   (bus_adr),
    .bus_dat_o (bus_dat_o),
    .bus_ack   (bus_ack)
);

// File: tb/hexbr_bridge_bench.sv
module hexbr_bridge_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  in_data;
    logic        in_valid;
    logic        in_ready;
    logic [6:0]  con_data;
    logic        con_valid;
    logic        con_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        bus_cyc;
    logic        bus_stb;
    logic        bus_we;
    logic [31:0] bus_adr;
    logic [31:0] bus_dat_o;
    logic [31:0] bus_dat_i;
    logic        bus_ack;

    always #2.5 clk = ~clk;

    hexbr_bridge u_hexbr_bridge (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .con_data(con_data), .con_valid(con_valid), .con_ready(con_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_dat_o(bus_dat_o),
        .bus_dat_i(bus_dat_i), .bus_ack(bus_ack)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string hx     = "0123456789ABCDEF";

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- bus slave and sink pacing ----------------
    logic [31:0] smem [16];
    int tick = 0;
    int wcnt = 0;

    initial begin
        for (int i = 0; i < 16; i++) smem[i] = 32'h0;
        bus_ack = 1'b0; bus_dat_i = 32'h0; tx_ready = 1'b0; con_ready = 1'b0;
    end

    always @(posedge clk) begin
        #1;
        tick++;
        tx_ready  = (tick % 4) != 1;
        con_ready = (tick % 5) != 2;
        if (bus_cyc && !bus_ack) begin
            if (wcnt >= int'(bus_adr[1:0])) begin
                bus_ack   = 1'b1;
                bus_dat_i = smem[bus_adr[3:0]];
                if (bus_we) smem[bus_adr[3:0]] = bus_dat_o;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            bus_ack = 1'b0;
        end
    end

    // ---------------- behavioural reference model ----------------
    logic [31:0] maddr = 0;
    logic [31:0] mword = 0;
    logic [31:0] mmem [16];
    logic [7:0]  mcmd  = 0;
    int          mpos  = 0;
    bit          pend  = 0;
    bit          pwe   = 0;
    logic [31:0] pdat  = 0;
    logic [7:0]  q [$];
    bit          mb;
    int n_cyc = 0, n_acks = 0, n_tx = 0, n_con = 0;
    logic [31:0] last_adr = 0;

    initial for (int i = 0; i < 16; i++) mmem[i] = 32'h0;

    function automatic bit m_ishex(input logic [6:0] c);
        return (c >= "0" && c <= "9") || (c >= "a" && c <= "f") || (c >= "A" && c <= "F");
    endfunction

    function automatic logic [3:0] m_val(input logic [6:0] c);
        if (c >= "0" && c <= "9") return 4'(c - "0");
        if (c >= "a" && c <= "f") return 4'(c - "a" + 10);
        return 4'(c - "A" + 10);
    endfunction

    task automatic model_char(input logic [6:0] c);
        if (mpos < 8) begin
            if (m_ishex(c)) begin mword = {mword[27:0], m_val(c)}; mpos++; end
            else mpos = 0;
        end else if (mpos == 8) begin
            if (c == "A" || c == "W" || c == "R") begin mcmd = {1'b0, c}; mpos = 9; end
            else mpos = 0;
        end else if (mpos == 9) begin
            mpos = (c == 7'h0D) ? 10 : 0;
        end else begin
            mpos = 0;
            if (c == 7'h0A) begin
                if (mcmd == "A") maddr = mword;
                else if (mcmd == "W") begin pend = 1; pwe = 1; pdat = mword; end
                else begin pend = 1; pwe = 0; end
            end
        end
    endtask

    task automatic model_complete();
        logic [31:0] v;
        last_adr = maddr;
        if (pwe) begin
            mmem[maddr[3:0]] = pdat;
            q.push_back("K"); q.push_back(8'h0D); q.push_back(8'h0A);
        end else begin
            v = mmem[maddr[3:0]];
            for (int i = 0; i < 8; i++) q.push_back(hx[(v >> (28 - 4*i)) & 32'hF]);
            q.push_back("R"); q.push_back(8'h0D); q.push_back(8'h0A);
        end
        maddr = maddr + 1;
        pend  = 0;
        n_acks++;
    endtask

    // compares each cycle, mid-cycle, what the next edge will see
    always @(negedge clk) begin
        if (!rst) begin
            mb = pend || (q.size() != 0);
            chk(in_ready == (!mb && (!in_data[7] || con_ready)), "R9 in_ready",
                in_ready, (!mb && (!in_data[7] || con_ready)));
            chk(con_valid == (in_valid && in_data[7] && !mb), "R1 con_valid",
                con_valid, (in_valid && in_data[7] && !mb));
            if (con_valid) chk(con_data == in_data[6:0], "R1 con_data", con_data, in_data[6:0]);
            chk(bus_cyc == pend, "R4 R5 bus_cyc", bus_cyc, pend);
            if (bus_cyc) begin
                n_cyc++;
                chk(bus_stb, "R4 bus_stb", bus_stb, 1);
                chk(bus_adr == maddr, "R7 bus_adr", bus_adr, maddr);
                chk(bus_we == pwe, "R4 R5 bus_we", bus_we, pwe);
                if (pwe) chk(bus_dat_o == pdat, "R4 bus_dat_o", bus_dat_o, pdat);
            end
            chk(tx_valid == (q.size() != 0), "R10 tx_valid", tx_valid, q.size() != 0);
            if (tx_valid && q.size() != 0)
                chk(tx_data == q[0], "R5 R6 tx byte", tx_data, q[0]);
            if (tx_valid && tx_ready && q.size() != 0) begin
                void'(q.pop_front());
                n_tx++;
            end
            if (bus_cyc && bus_ack && pend) model_complete();
            if (in_valid && in_ready) begin
                if (in_data[7]) n_con++;
                else model_char(in_data[6:0]);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
    endtask

    task automatic idle_in();
        in_valid = 1'b0;
        in_data  = 8'h00;
    endtask

    task automatic put_str(input string s);
        for (int i = 0; i < s.len(); i++) put(s[i]);
        idle_in();
    endtask

    task automatic send_frame(input logic [31:0] w, input byte cmd, input bit lower, input int con_at);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] c;
            c = hx[(w >> (28 - 4*i)) & 32'hF];
            if (lower && c >= "A") c = c + 8'd32;
            if (i == con_at) put(8'hC1);
            put(c);
        end
        put(cmd); put(8'h0D); put(8'h0A);
        idle_in();
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (pend || q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        rst = 1'b1;
        idle_in();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!bus_cyc && !bus_stb, "R11 reset bus idle", bus_cyc, 0);
        chk(!tx_valid, "R11 reset tx idle", tx_valid, 0);
        chk(!con_valid, "R11 reset console idle", con_valid, 0);
        chk(in_ready, "R11 reset ready", in_ready, 1);
        @(posedge clk); #1;

        // R11: first read at address 0 proves the reset address
        send_frame(32'h0, "R", 0, -1);
        wait_idle();
        chk(last_adr == 0 && n_acks == 1, "R11 reset address", last_adr, 0);

        // R3: load only
        send_frame(32'h5, "A", 0, -1);
        wait_idle();
        chk(n_acks == 1, "R3 load makes no bus cycle", n_acks, 1);
        chk(n_tx == 11, "R3 load makes no reply", n_tx, 11);

        // R4 R6: write, uppercase digits
        send_frame(32'hDEADBEEF, "W", 0, -1);
        wait_idle();
        chk(n_acks == 2, "R4 write done", n_acks, 2);
        chk(n_tx == 14, "R6 write reply length", n_tx, 14);

        // R2 R1: lowercase digits with a console byte inside the frame
        send_frame(32'hCAFEF00D, "W", 1, 3);
        wait_idle();
        chk(n_acks == 3 && last_adr == 6, "R2 lowercase frame written at 6", last_adr, 6);
        chk(n_con == 1, "R1 console byte in frame", n_con, 1);

        // R5 R7: read back both words with auto-increment
        send_frame(32'h5, "A", 0, -1);
        send_frame(32'h0, "R", 0, -1);
        send_frame(32'h0, "R", 0, -1);
        wait_idle();
        chk(n_acks == 5 && last_adr == 6, "R7 second read at next address", last_adr, 6);
        chk(n_tx == 17 + 22, "R5 read reply length", n_tx, 39);

        // R8: malformed frames leave everything untouched
        put_str("12G");
        put_str("123456789W\r\n");
        put_str("0000000AX\r\n");
        put_str("00000003A\r\r");
        put_str("0000000BQ\r\n");
        wait_idle();
        chk(n_acks == 5, "R8 no bus cycle from bad frames", n_acks, 5);
        send_frame(32'h0, "R", 0, -1);
        wait_idle();
        chk(last_adr == 7, "R8 address kept after bad frames", last_adr, 7);

        // R2: mixed case digits round trip
        send_frame(32'h3, "A", 0, -1);
        put_str("aBcD1234W\r\n");
        send_frame(32'h3, "A", 0, -1);
        send_frame(32'h0, "R", 0, -1);
        wait_idle();
        chk(n_acks == 8 && mmem[3] == 32'hABCD1234, "R2 mixed case word", mmem[3], 32'hABCD1234);

        // R1: console burst with back-pressure
        put(8'hE8); put(8'hFF); put(8'h80); put(8'hC1);
        idle_in();
        wait_idle();
        chk(n_con == 5, "R1 console burst count", n_con, 5);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule